// File: doc/BRIEF.md
# I2C Master Byte-Receive Sequencer

This block is the receive half of an I2C bus master's command path. Software writes a command word. Two of its bits ask for one byte to be read from the bus: a plain receive, which answers the byte with ACK, and a final receive, which answers it with NACK. Once the byte is in, the block writes it into a byte buffer register, raises a receive-done flag and clears both request bits. A 4-bit transfer state code in the command word shows when the master is shifting in data.

The bit-level bus engine sits on the far side of three valid/ready channels: a byte request, a byte response carrying data and an error flag, and an ACK/NACK decision. The block holds each valid high until ready is seen. It only offers `rsp_ready` while it waits for a byte, and the engine may stall any channel for as long as it needs.

While receive-done is set, no new receive starts. Software must first clear the flag through the write-one-to-clear status port. A command write wipes every other status bit and leaves receive-done alone.

Top module: `i2c_mrx_seq`

## Requirements
- R1: A command write loads `cmd_wr_data` into `cmd_q[15:0]` on the next edge. Bits [31:16] of `cmd_q` are never changed by a write. The only upper field is the transfer state at [22:19], and every other upper bit stays 0.
- R2: A receive starts when the sequencer is idle, receive-done (`sts_q[2]`) is 0, and `cmd_q[3]` (receive) or `cmd_q[4]` (final receive) is 1. `rd_req_valid` rises one edge after that condition is present in the registers, which is two edges after the command write.
- R3: On the edge that takes a command write, every status bit except bit 2 is cleared and bit 2 keeps its value. Event bits arriving in that same cycle still get set.
- R4: While `sts_q[2]` is 1, no byte request is issued. A receive command that is pending starts one edge after software clears the flag.
- R5: The transfer state `cmd_q[22:19]` is 0 after reset. It reads 3 (receiving) from the edge a receive starts up to its completion edge, and 1 (active) from then on.
- R6: A response accepted with `rsp_err`=0 loads its byte into `rxbuf_q[15:8]` on the accept edge. Every other buffer bit stays 0. `sts_q[2]` is set on the completion edge.
- R7: A response accepted with `rsp_err`=1 loads 0xFF into `rxbuf_q[15:8]`, and `sts_q[2]` is not set for that byte.
- R8: `ack_nack` is 1 (NACK) if `cmd_q[4]` was 1 when the receive started, and 0 (ACK) otherwise.
- R9: On the completion edge (`ack_valid` and `ack_ready` both high) `cmd_q[3]` and `cmd_q[4]` are cleared, unless a command write lands on that same edge, in which case the write wins.
- R10: `rd_req_valid`, and `ack_valid` together with `ack_nack`, stay high and stable until their ready is seen. `rsp_ready` is high only between the request handshake and the response handshake.
- R11: A status clear drops the bits set in `sts_clr_mask`. An event or completion set in the same cycle wins over the clear. Bit 2 of `sts_evt_set` has no effect.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command write strobe |
| cmd_wr_data | input | 16 | New value for the low half of the command word |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 15 | Status bits to clear (write one to clear) |
| sts_evt_set | input | 15 | Status set pulses from other controller parts |
| cmd_q | output | 32 | Command word: request bits in the low half, transfer state at [22:19] |
| sts_q | output | 15 | Status flags, bit 2 is receive-done |
| rxbuf_q | output | 32 | Byte buffer, received byte at [15:8] |
| rd_req_valid | output | 1 | Byte request to the bus engine |
| rd_req_ready | input | 1 | Bus engine accepts the request |
| rsp_valid | input | 1 | Byte response available |
| rsp_ready | output | 1 | Sequencer accepts a response |
| rsp_data | input | 8 | Byte shifted in from the bus |
| rsp_err | input | 1 | The bus read failed |
| ack_valid | output | 1 | ACK/NACK decision available |
| ack_ready | input | 1 | Bus engine takes the decision |
| ack_nack | output | 1 | 1 = NACK, 0 = ACK |

## Verification
Every output comes from a register, so each result appears exactly one edge after the cycle that causes it:
- a written command reaches `cmd_q` one edge after the write;
- the byte request follows one edge after that;
- the buffer loads on the response edge;
- receive-done, the state code and the request-bit clear all move on the ACK handshake edge.

A behavioural model in the bench advances on the same edges from the same input values. The bench compares it against the ports 1 ns after each edge, while all inputs change on falling edges. Directed checks add a count of edges from write to request, a blocked command held for ten cycles, and the error and NACK paths.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2,
    PH_ACK  = 2'd3
  } rx_phase_e;

  localparam int          XS_W      = 4;
  localparam logic [3:0]  XS_RESET  = 4'h0;
  localparam logic [3:0]  XS_ACTIVE = 4'h1;
  localparam logic [3:0]  XS_RXD    = 4'h3;

endpackage

// File: rtl/i2c_mrx_fsm.sv
module i2c_mrx_fsm
  import i2c_mrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_req_i,
  input  logic              last_req_i,
  input  logic              done_i,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic              ack_nack,
  output logic              start_o,
  output logic              cap_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              fin_o,
  output logic              fin_ok_o
);

  rx_phase_e phase_q;
  logic      last_q;
  logic      err_q;

  assign start_o    = (phase_q == PH_IDLE) && (rx_req_i || last_req_i) && !done_i;
  assign cap_o      = (phase_q == PH_WAIT) && rsp_valid;
  assign cap_data_o = rsp_err ? {DATA_W{1'b1}} : rsp_data;
  assign fin_o      = (phase_q == PH_ACK) && ack_ready;
  assign fin_ok_o   = fin_o && !err_q;

  assign rd_req_valid = (phase_q == PH_REQ);
  assign rsp_ready    = (phase_q == PH_WAIT);
  assign ack_valid    = (phase_q == PH_ACK);
  assign ack_nack     = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_o) begin
          phase_q <= PH_REQ;
          last_q  <= last_req_i;
        end
        PH_REQ:  if (rd_req_ready) phase_q <= PH_WAIT;
        PH_WAIT: if (rsp_valid) begin
          phase_q <= PH_ACK;
          err_q   <= rsp_err;
        end
        PH_ACK:  if (ack_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid);

  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid && $stable(ack_nack));

endmodule

// File: rtl/i2c_mrx_status.sv
module i2c_mrx_status #(
  parameter int STS_W    = 15,
  parameter int DONE_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             clr_en,
  input  logic [STS_W-1:0] clr_mask,
  input  logic [STS_W-1:0] evt_set,
  input  logic             done_set,
  output logic [STS_W-1:0] sts_q
);

  localparam logic [STS_W-1:0] DONE_M = STS_W'(1) << DONE_BIT;

  logic unused_evt_done;
  assign unused_evt_done = evt_set[DONE_BIT];

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    localparam bit KEEP_ON_CMD = (i == DONE_BIT);
    logic set_i;
    logic hold_i;
    if (KEEP_ON_CMD) begin : g_done
      assign set_i = done_set;
    end else begin : g_evt
      assign set_i = evt_set[i];
    end
    assign hold_i = sts_q[i] && !(clr_en && clr_mask[i]) && (KEEP_ON_CMD || !cmd_wr);
    always_ff @(posedge clk) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= hold_i || set_i;
    end
  end

  // R3
  cmd_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (evt_set == '0) |=> (sts_q & ~DONE_M) == '0);

  // R3
  cmd_keep_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !clr_en && !done_set |=> sts_q[DONE_BIT] == $past(sts_q[DONE_BIT]));

  // R11
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !cmd_wr && (evt_set == '0) && !done_set |=> (sts_q & $past(clr_mask)) == '0);

endmodule

// File: rtl/i2c_mrx_regs.sv
module i2c_mrx_regs
  import i2c_mrx_pkg::*;
#(
  parameter int CMD_W    = 32,
  parameter int WR_W     = 16,
  parameter int RX_BIT   = 3,
  parameter int LAST_BIT = 4,
  parameter int XS_LSB   = 19,
  parameter int DATA_W   = 8,
  parameter int BUF_W    = 32,
  parameter int BUF_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WR_W-1:0]   cmd_wdata,
  input  logic              start,
  input  logic              fin,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [BUF_W-1:0]  buf_q
);

  logic [WR_W-1:0]   lo_q;
  logic [XS_W-1:0]   xs_q;
  logic [DATA_W-1:0] rxb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cmd_wr) begin
      lo_q <= cmd_wdata;
    end else if (fin) begin
      lo_q[RX_BIT]   <= 1'b0;
      lo_q[LAST_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     xs_q <= XS_RESET;
    else if (start) xs_q <= XS_RXD;
    else if (fin)   xs_q <= XS_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rxb_q <= '0;
    else if (cap) rxb_q <= cap_data;
  end

  always_comb begin
    cmd_q                  = '0;
    cmd_q[WR_W-1:0]        = lo_q;
    cmd_q[XS_LSB +: XS_W]  = xs_q;
    buf_q                  = '0;
    buf_q[BUF_LSB +: DATA_W] = rxb_q;
  end

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !cmd_wr |=> !cmd_q[RX_BIT] && !cmd_q[LAST_BIT]);

  // R1
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !start && !fin |=> cmd_q[CMD_W-1:WR_W] == $past(cmd_q[CMD_W-1:WR_W]));

  // R5
  state_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> cmd_q[XS_LSB +: XS_W] == XS_ACTIVE);

endmodule

// File: rtl/i2c_mrx_seq.sv
module i2c_mrx_seq
  import i2c_mrx_pkg::*;
#(
  parameter int CMD_W    = 32,
  parameter int WR_W     = 16,
  parameter int STS_W    = 15,
  parameter int DATA_W   = 8,
  parameter int BUF_W    = 32,
  parameter int RX_BIT   = 3,
  parameter int LAST_BIT = 4,
  parameter int DONE_BIT = 2,
  parameter int XS_LSB   = 19,
  parameter int BUF_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_en,
  input  logic [WR_W-1:0]   cmd_wr_data,
  input  logic              sts_clr_en,
  input  logic [STS_W-1:0]  sts_clr_mask,
  input  logic [STS_W-1:0]  sts_evt_set,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [STS_W-1:0]  sts_q,
  output logic [BUF_W-1:0]  rxbuf_q,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic              ack_nack
);

  logic              start, cap, fin, fin_ok;
  logic [DATA_W-1:0] cap_data;

  i2c_mrx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk, .rst_n,
    .rx_req_i   (cmd_q[RX_BIT]),
    .last_req_i (cmd_q[LAST_BIT]),
    .done_i     (sts_q[DONE_BIT]),
    .rd_req_valid, .rd_req_ready,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_err,
    .ack_valid, .ack_ready, .ack_nack,
    .start_o    (start),
    .cap_o      (cap),
    .cap_data_o (cap_data),
    .fin_o      (fin),
    .fin_ok_o   (fin_ok)
  );

  i2c_mrx_status #(.STS_W(STS_W), .DONE_BIT(DONE_BIT)) u_sts (
    .clk, .rst_n,
    .cmd_wr   (cmd_wr_en),
    .clr_en   (sts_clr_en),
    .clr_mask (sts_clr_mask),
    .evt_set  (sts_evt_set),
    .done_set (fin_ok),
    .sts_q    (sts_q)
  );

  i2c_mrx_regs #(
    .CMD_W(CMD_W), .WR_W(WR_W), .RX_BIT(RX_BIT), .LAST_BIT(LAST_BIT),
    .XS_LSB(XS_LSB), .DATA_W(DATA_W), .BUF_W(BUF_W), .BUF_LSB(BUF_LSB)
  ) u_regs (
    .clk, .rst_n,
    .cmd_wr    (cmd_wr_en),
    .cmd_wdata (cmd_wr_data),
    .start, .fin, .cap,
    .cap_data  (cap_data),
    .cmd_q     (cmd_q),
    .buf_q     (rxbuf_q)
  );

  // R4
  no_start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> !$past(sts_q[DONE_BIT]));

  // R5
  rx_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || rsp_ready || ack_valid) |-> cmd_q[XS_LSB +: XS_W] == XS_RXD);

  // R7
  err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready && rsp_valid && rsp_err |=> rxbuf_q[BUF_LSB +: DATA_W] == {DATA_W{1'b1}});

  // R10
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, rsp_ready, ack_valid}));

endmodule

// File: tb/tb_i2c_mrx_seq.sv
`timescale 1ns/1ps
module tb_i2c_mrx_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr_en = 1'b0;
  logic [15:0] cmd_wr_data = '0;
  logic        sts_clr_en = 1'b0;
  logic [14:0] sts_clr_mask = '0;
  logic [14:0] sts_evt_set = '0;
  logic [31:0] cmd_q;
  logic [14:0] sts_q;
  logic [31:0] rxbuf_q;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [7:0]  rsp_data = '0;
  logic        rsp_err = 1'b0;
  logic        ack_valid, ack_ready = 1'b0, ack_nack;

  int checks = 0;
  int errors = 0;
  int req_rises = 0;
  logic last_nack = 1'b0;
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mrx_seq dut (.*);

  // behavioural reference
  logic [31:0] m_cmd;
  logic [14:0] m_sts;
  logic [31:0] m_buf;
  int          m_ph;
  logic        m_last, m_err;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit started, fin, ok;
    logic [14:0] ns;
    started = 0; fin = 0; ok = 0;
    if (!rst_n) begin
      m_cmd = '0; m_sts = '0; m_buf = '0; m_ph = 0; m_last = 0; m_err = 0;
      return;
    end
    case (m_ph)
      0: if ((m_cmd[3] || m_cmd[4]) && !m_sts[2]) begin
           m_ph = 1; m_last = m_cmd[4]; started = 1;
         end
      1: if (rd_req_ready) m_ph = 2;
      2: if (rsp_valid) begin
           m_buf = {16'h0, (rsp_err ? 8'hFF : rsp_data), 8'h0};
           m_err = rsp_err; m_ph = 3;
         end
      default: if (ack_ready) begin m_ph = 0; fin = 1; ok = !m_err; end
    endcase
    if (cmd_wr_en) m_cmd[15:0] = cmd_wr_data;
    else if (fin) begin m_cmd[3] = 0; m_cmd[4] = 0; end
    if (started) m_cmd[22:19] = 4'h3;
    else if (fin) m_cmd[22:19] = 4'h1;
    ns = m_sts;
    if (sts_clr_en) ns = ns & ~sts_clr_mask;
    if (cmd_wr_en)  ns = ns & 15'h0004;
    ns = ns | (sts_evt_set & ~15'h0004);
    if (ok) ns = ns | 15'h0004;
    m_sts = ns;
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    if (rd_req_valid && !prev_req) req_rises++;
    prev_req = rd_req_valid;
    if (ack_valid) last_nack = ack_nack;
    chk("R10 req_valid", {31'h0, rd_req_valid}, {31'h0, m_ph == 1});
    chk("R10 rsp_ready", {31'h0, rsp_ready}, {31'h0, m_ph == 2});
    chk("R10 ack_valid", {31'h0, ack_valid}, {31'h0, m_ph == 3});
    if (ack_valid) chk("R8 ack_nack", {31'h0, ack_nack}, {31'h0, m_last});
    chk("R1/R9 cmd_low", {16'h0, cmd_q[15:0]}, {16'h0, m_cmd[15:0]});
    chk("R5 state", {28'h0, cmd_q[22:19]}, {28'h0, m_cmd[22:19]});
    chk("R1 cmd_upper", {cmd_q[31:23], 4'h0, cmd_q[18:16], 16'h0}, 32'h0);
    chk("R6/R7 rxbuf", rxbuf_q, m_buf);
    chk("R3/R11 status", {17'h0, sts_q}, {17'h0, m_sts});
  end

  task automatic nclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cmd(logic [15:0] d);
    @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = d;
    @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic clr(logic [14:0] m);
    @(negedge clk); sts_clr_en = 1'b1; sts_clr_mask = m;
    @(negedge clk); sts_clr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int r0;
    nclk(3);
    // R12 reset state
    chk("R12 cmd", cmd_q, 32'h0);
    chk("R12 sts", {17'h0, sts_q}, 32'h0);
    chk("R12 buf", rxbuf_q, 32'h0);
    chk("R12 handshake", {29'h0, rd_req_valid, rsp_ready, ack_valid}, 32'h0);
    rst_n = 1'b1;
    nclk(2);
    rd_req_ready = 1; rsp_valid = 1; ack_ready = 1; rsp_data = 8'h5A;

    // status events then a receive command
    @(negedge clk); sts_evt_set = 15'h0021;
    @(negedge clk); sts_evt_set = '0;
    chk("R11 evt", {17'h0, sts_q}, 32'h21);
    @(negedge clk); cmd_wr_en = 1; cmd_wr_data = 16'h0008;
    @(negedge clk); cmd_wr_en = 0;
    chk("R3 wipe", {17'h0, sts_q}, 32'h0);
    chk("R2 no req yet", {31'h0, rd_req_valid}, 32'h0);
    @(negedge clk);
    chk("R2 req after 2 edges", {31'h0, rd_req_valid}, 32'h1);
    chk("R5 receiving", {28'h0, cmd_q[22:19]}, 32'h3);
    nclk(6);
    chk("R6 byte", {24'h0, rxbuf_q[15:8]}, 32'h5A);
    chk("R6 done", {31'h0, sts_q[2]}, 32'h1);
    chk("R9 bits", {30'h0, cmd_q[4:3]}, 32'h0);
    chk("R5 active", {28'h0, cmd_q[22:19]}, 32'h1);
    chk("R8 ack", {31'h0, last_nack}, 32'h0);

    // blocked final receive
    rsp_data = 8'hC3;
    r0 = req_rises;
    wr_cmd(16'h0010);
    chk("R3 keep done", {31'h0, sts_q[2]}, 32'h1);
    nclk(10);
    chk("R4 blocked", req_rises, r0);
    clr(15'h0004);
    nclk(8);
    chk("R4 resumes", req_rises, r0 + 1);
    chk("R8 nack", {31'h0, last_nack}, 32'h1);
    chk("R6 byte2", {24'h0, rxbuf_q[15:8]}, 32'hC3);

    // failed read
    clr(15'h0004);
    rsp_err = 1;
    wr_cmd(16'h0008);
    nclk(8);
    chk("R7 fill", {24'h0, rxbuf_q[15:8]}, 32'hFF);
    chk("R7 no done", {31'h0, sts_q[2]}, 32'h0);
    rsp_err = 0;

    // bit 2 of event set ignored, mask clear
    @(negedge clk); sts_evt_set = 15'h7FFF;
    @(negedge clk); sts_evt_set = '0;
    chk("R11 ignore", {17'h0, sts_q}, 32'h7FFB);
    clr(15'h00F0);
    chk("R11 clear", {17'h0, sts_q}, 32'h7F0B);

    // random traffic with stalls, compared against the model each edge
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd_req_ready = ($urandom % 3) == 0;
      rsp_valid    = ($urandom % 3) == 0;
      ack_ready    = ($urandom % 2) == 0;
      rsp_data     = 8'($urandom);
      rsp_err      = ($urandom % 4) == 0;
      cmd_wr_en    = ($urandom % 9) == 0;
      cmd_wr_data  = 16'($urandom);
      sts_clr_en   = ($urandom % 5) == 0;
      sts_clr_mask = 15'($urandom);
      sts_evt_set  = (($urandom % 10) == 0) ? 15'($urandom) : 15'h0;
    end
    @(negedge clk);
    cmd_wr_en = 0; sts_clr_en = 0; sts_evt_set = '0;
    nclk(4);
    summary();
  end

endmodule